// File: doc/BRIEF.md
# Wake-Up Phase Sequencer

This block brings a freshly configured device out of its configuration state in a controlled order. Once loading has finished, it walks through four clock-driven phases, T0 to T3, on a dedicated start-up clock. Four release controls each become active in a phase of their own:

- the release of the configuration-complete pin;
- the global output enable;
- the release of the global write-disable;
- the release of the global set/reset.

A control that has become active stays active until reset. One clock after T3 a wake-complete flag goes high.

Each control is given its release phase by a 2-bit assignment input. An external-gating option changes how the sequence starts. With the option off, the sequence starts from the internal completion event and pays no attention to the sensed level of the completion pin. With the option on, the sequence also waits for that pin to be sensed high. The option also narrows the set of legal assignments and forces the pin driver into open-drain mode. An illegal assignment set is replaced as a whole by the default set for the current option setting.

Top module: `wake_seq`

## Requirements
- R1: While rst_ni is low, and after it is released until the sequence starts, done_rel_o, goe_o, gwd_rel_o, gsr_rel_o and wake_o are all low.
- R2: With done_ex_i low, the rising clock edge that samples done_bit_i high enters phase T0. done_pin_i has no effect on when the sequence starts.
- R3: With done_ex_i high, T0 is entered on the first rising edge at which done_pin_i is sampled high and the internal completion has already been recorded, either at that edge or earlier. Until then all four controls stay low.
- R4: Phases advance T0, T1, T2, T3 on consecutive rising edges. A control whose assigned phase is p (value p on its 2-bit input means Tp) goes high at the edge that enters Tp. It stays high until reset.
- R5: wake_o goes high on the rising edge after the one that entered T3. It stays high until reset, and all four controls are then high.
- R6: The four assignments and done_ex_i are captured at the edge that enters T0. Later changes on those inputs do not alter the control outputs.
- R7: With done_ex_i low, every assignment set is legal. With done_ex_i high, a set is legal only when the completion-pin control is assigned T0 and no other control is assigned T3. An illegal set is replaced as a whole by the default set for the captured done_ex_i.
- R8: The default set with done_ex_i low is: completion pin in T3, output enable in T1, write-disable and set/reset in T2. With done_ex_i high it is: completion pin in T0, output enable in T1, write-disable and set/reset in T2.
- R9: done_od_o is high whenever done_ex_i or od_req_i is high. With done_ex_i high, od_req_i has no effect.
- R10: A done_bit_i pulse of a single cycle is remembered while the sequence waits for done_pin_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Start-up clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_bit_i | input | 1 | Internal configuration-complete event |
| done_pin_i | input | 1 | Sensed level of the external completion pin |
| done_ex_i | input | 1 | External-gating option |
| od_req_i | input | 1 | Requests open-drain mode for the completion pin |
| ph_done_i | input | 2 | Release phase of the completion pin |
| ph_goe_i | input | 2 | Phase of the global output enable |
| ph_gwd_i | input | 2 | Release phase of the global write-disable |
| ph_gsr_i | input | 2 | Release phase of the global set/reset |
| done_rel_o | output | 1 | Release of the completion pin |
| goe_o | output | 1 | Global output enable |
| gwd_rel_o | output | 1 | Global write-disable released |
| gsr_rel_o | output | 1 | Global set/reset released |
| done_od_o | output | 1 | Completion pin driven open-drain |
| wake_o | output | 1 | Wake-up complete |

## Verification
Two events can fall in the same cycle: the capture of the assignment set at the start edge, and a change of those same assignment inputs. The bench inverts every assignment in the cycle right after the start edge. Each later phase is then judged against the set that was present at the start edge, after legality fallback.

The second coincidence is between the internal completion event and the sensed pin level. With gating off, the pin is driven in a pattern that varies from one assignment set to the next, so it is sometimes high together with the completion event and sometimes high with no completion event at all. Neither case may move the start. With gating on, a single-cycle completion pulse arrives while the pin is still low, and the start must follow the later rise of the pin by exactly one edge. The sweep covers all 256 assignment sets under both option settings.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  localparam int unsigned N_PH  = 4;
  localparam int unsigned PW    = $clog2(N_PH);
  localparam int unsigned N_CTL = 4;

  localparam int unsigned CTL_DONE = 0;
  localparam int unsigned CTL_GOE  = 1;
  localparam int unsigned CTL_GWD  = 2;
  localparam int unsigned CTL_GSR  = 3;

  localparam logic [PW-1:0] PH_LAST = PW'(N_PH - 1);

  typedef logic [PW-1:0] ph_t;
  typedef ph_t [N_CTL-1:0] ph_set_t;

  function automatic ph_set_t dflt_set(input logic ex);
    ph_set_t s;
    s[CTL_DONE] = ex ? ph_t'(0) : PH_LAST;
    s[CTL_GOE]  = ph_t'(1);
    s[CTL_GWD]  = ph_t'(2);
    s[CTL_GSR]  = ph_t'(2);
    return s;
  endfunction

  function automatic logic set_legal(input logic ex, input ph_set_t s);
    logic ok;
    ok = 1'b1;
    if (ex) begin
      if (s[CTL_DONE] != ph_t'(0)) ok = 1'b0;
      for (int k = 0; k < N_CTL; k++)
        if (k != CTL_DONE && s[k] == PH_LAST) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/wake_seq_trig.sv
module wake_seq_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic done_bit_i,
  input  logic done_pin_i,
  input  logic done_ex_i,
  output logic start_o
);
  logic armed_q;
  logic seen;

  // remember a short completion pulse until the pin gate opens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (done_bit_i) armed_q <= 1'b1;
  end

  assign seen    = armed_q | done_bit_i;
  assign start_o = !busy_i && seen && (!done_ex_i || done_pin_i);
endmodule

// File: rtl/wake_seq_sel.sv
module wake_seq_sel
  import wake_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    done_ex_i,
  input  ph_set_t sel_i,
  output ph_set_t sel_q_o,
  output logic    ex_q_o
);
  ph_set_t sel_eff;

  always_comb begin
    sel_eff = sel_i;
    if (!set_legal(done_ex_i, sel_i)) sel_eff = dflt_set(done_ex_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q_o <= dflt_set(1'b0);
      ex_q_o  <= 1'b0;
    end else if (start_i) begin
      sel_q_o <= sel_eff;
      ex_q_o  <= done_ex_i;
    end
  end
endmodule

// File: rtl/wake_seq_ctr.sv
module wake_seq_ctr #(
  parameter int unsigned N_PH = 4,
  localparam int unsigned PW = $clog2(N_PH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          run_o,
  output logic [PW-1:0] ph_o,
  output logic          wake_o
);
  localparam logic [PW-1:0] LAST = PW'(N_PH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      ph_o   <= '0;
      wake_o <= 1'b0;
    end else if (!run_o) begin
      if (start_i) begin
        run_o <= 1'b1;
        ph_o  <= '0;
      end
    end else if (ph_o != LAST) begin
      ph_o <= ph_o + 1'b1;
    end else begin
      wake_o <= 1'b1;
    end
  end

  p_phase_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && ph_o != LAST |=> run_o && ph_o == PW'($past(ph_o) + 1'b1));
  p_wake_time_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && ph_o == LAST |=> wake_o);
  p_start_t0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o && start_i |=> run_o && ph_o == '0 && !wake_o);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_bit_i,
  input  logic          done_pin_i,
  input  logic          done_ex_i,
  input  logic          od_req_i,
  input  logic [PW-1:0] ph_done_i,
  input  logic [PW-1:0] ph_goe_i,
  input  logic [PW-1:0] ph_gwd_i,
  input  logic [PW-1:0] ph_gsr_i,
  output logic          done_rel_o,
  output logic          goe_o,
  output logic          gwd_rel_o,
  output logic          gsr_rel_o,
  output logic          done_od_o,
  output logic          wake_o
);
  ph_set_t            sel_in, sel_q;
  logic               ex_q, run, start;
  logic [PW-1:0]      ph;
  logic [N_CTL-1:0]   ctl;

  assign sel_in[CTL_DONE] = ph_done_i;
  assign sel_in[CTL_GOE]  = ph_goe_i;
  assign sel_in[CTL_GWD]  = ph_gwd_i;
  assign sel_in[CTL_GSR]  = ph_gsr_i;

  wake_seq_trig u_trig (
    .clk_i, .rst_ni, .busy_i(run), .done_bit_i, .done_pin_i, .done_ex_i,
    .start_o(start)
  );

  wake_seq_sel u_sel (
    .clk_i, .rst_ni, .start_i(start), .done_ex_i, .sel_i(sel_in),
    .sel_q_o(sel_q), .ex_q_o(ex_q)
  );

  wake_seq_ctr #(.N_PH(N_PH)) u_ctr (
    .clk_i, .rst_ni, .start_i(start), .run_o(run), .ph_o(ph), .wake_o
  );

  for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
    assign ctl[k] = run && (ph >= sel_q[k]);

    p_ctl_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl[k] |=> ctl[k]);
  end

  assign done_rel_o = ctl[CTL_DONE];
  assign goe_o      = ctl[CTL_GOE];
  assign gwd_rel_o  = ctl[CTL_GWD];
  assign gsr_rel_o  = ctl[CTL_GSR];
  // gating by the sensed pin requires the pin not be actively driven
  assign done_od_o  = done_ex_i | od_req_i;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> ctl == '0 && !wake_o);
  p_ex_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && done_ex_i && !done_pin_i |=> !run);
  p_wake_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> &ctl);
  p_ex_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && ex_q |-> sel_q[CTL_DONE] == '0 && sel_q[CTL_GOE] != PH_LAST
                    && sel_q[CTL_GWD] != PH_LAST && sel_q[CTL_GSR] != PH_LAST);
endmodule

// File: tb/wake_seq_bench.sv
module wake_seq_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic done_bit_i = 1'b0, done_pin_i = 1'b0, done_ex_i = 1'b0, od_req_i = 1'b0;
  logic [1:0] ph_done_i = '0, ph_goe_i = '0, ph_gwd_i = '0, ph_gsr_i = '0;
  logic done_rel_o, goe_o, gwd_rel_o, gsr_rel_o, done_od_o, wake_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wake_seq u_wake_seq (
    .clk_i(clk), .rst_ni, .done_bit_i, .done_pin_i, .done_ex_i, .od_req_i,
    .ph_done_i, .ph_goe_i, .ph_gwd_i, .ph_gsr_i,
    .done_rel_o, .goe_o, .gwd_rel_o, .gsr_rel_o, .done_od_o, .wake_o
  );

  // packing: [1:0] done pin, [3:2] output enable, [5:4] write-disable, [7:6] set/reset
  function automatic logic [7:0] eff_set(input logic ex, input logic [7:0] s);
    logic ok;
    ok = !ex || (s[1:0] == 2'd0 && s[3:2] != 2'd3 && s[5:4] != 2'd3 && s[7:6] != 2'd3);
    if (ok) return s;
    return ex ? 8'b10_10_01_00 : 8'b10_10_01_11;   // R8 defaults
  endfunction

  task automatic apply_set(input logic [7:0] s);
    ph_done_i = s[1:0]; ph_goe_i = s[3:2]; ph_gwd_i = s[5:4]; ph_gsr_i = s[7:6];
  endtask

  // c < 0: idle; c >= 0: cycles since the edge entering T0
  task automatic check(input string tag, input int c, input logic [7:0] e);
    logic [5:0] act, exp;
    int ph;
    ph = (c > 3) ? 3 : c;
    exp[5] = (c >= 0) && (ph >= int'(e[1:0]));
    exp[4] = (c >= 0) && (ph >= int'(e[3:2]));
    exp[3] = (c >= 0) && (ph >= int'(e[5:4]));
    exp[2] = (c >= 0) && (ph >= int'(e[7:6]));
    exp[1] = (c >= 4);
    exp[0] = done_ex_i | od_req_i;
    act = {done_rel_o, goe_o, gwd_rel_o, gsr_rel_o, wake_o, done_od_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d set %b: got %b expected %b", tag, c, e, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int ex = 0; ex < 2; ex++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] sv, e;
        sv = 8'(s);
        e = eff_set(1'(ex), sv);
        rst_ni = 1'b0; done_bit_i = 1'b0;
        done_ex_i = 1'(ex);
        od_req_i = sv[2];
        done_pin_i = (ex == 1) ? 1'b0 : (sv[0] ^ sv[7]);
        apply_set(sv);
        @(posedge clk); #1;
        check("R1 R9 reset", -1, e);
        rst_ni = 1'b1;
        @(posedge clk); #1;
        check("R1 R2 idle before completion", -1, e);
        done_bit_i = 1'b1;
        if (ex == 1) begin
          // R10 single-cycle pulse while pin low; R3 must wait
          @(posedge clk); #1 done_bit_i = 1'b0;
          check("R3 R10 wait for pin", -1, e);
          @(posedge clk); #1;
          check("R3 R10 still waiting", -1, e);
          done_pin_i = 1'b1;
        end
        @(posedge clk); #1;
        done_bit_i = 1'b0;
        apply_set(~sv);            // R6 changes after capture
        done_pin_i = ~done_pin_i;  // R2 pin ignored / R3 already started
        check("R2 R3 R4 R7 T0", 0, e);
        for (int c = 1; c < 7; c++) begin
          @(posedge clk); #1;
          check("R4 R5 R6 R7 R8 phase", c, e);
        end
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule